// File: doc/BRIEF.md
# Timing Reference Cell Sequence Tracker

This block sits on the receive side of a cell interface and picks out the cells that carry the timing reference. It sees one cell per handshake: the cell's VPI, its VCI, a flag marking maintenance (OAM) cells, and the single AAL1 header byte that opens the payload. Cells whose VPI and VCI both equal the programmed pair, and that are not OAM cells, are timing cells. Their 3-bit sequence count is followed by a small tracking state machine. Each timing cell it accepts as part of the running sequence produces a one-cycle `new_cell` pulse, which paces an adaptive clock recovery loop downstream.

The tracker absorbs a single anomaly: one lost cell, one inserted duplicate, or one cell whose sequence protection is corrupt. It keeps the pulse count right across that anomaly and does not raise an error. A second anomaly before the sequence is confirmed again raises a sticky out-of-sync flag, and the tracker goes back to hunting for sequence. A separate timer counts ticks of an 8 kHz strobe. It raises a sticky loss-of-reference flag when no timing cell arrives within a programmable number of ticks.

The cell input is a valid/ready stream. `cell_ready` is high except for exactly one cycle after a cell that reveals a single lost cell, while the tracker emits the second of its two pulses. A source must hold `cell_valid` and the cell fields steady until a cycle in which `cell_ready` is high. Cells that are not timing cells are still consumed by the handshake and are then ignored.

Top module: `tref_seq_tracker`

## Requirements
- R1: A cell is a timing cell only when `cell_vpi` equals `cfg_vpi` and `cell_vci` equals `cfg_vci`. A cell that differs in either field produces no pulse and leaves the tracked sequence unchanged.
- R2: A cell with `cell_oam` high produces no pulse and leaves the sequence unchanged, even when its VPI and VCI match.
- R3: Header byte layout: bit 7 is the CSI bit, bits 6:4 are the sequence count, bits 3:1 are the remainder of (bits 7:4 times x^3) modulo x^3+x+1, and bit 0 makes the count of ones in the whole byte even. The protection is good when both checks pass. When `cfg_snp_en` is low, every header is treated as good.
- R4: After reset, and after leaving out-of-sync, the tracker hunts for sequence. It needs two consecutive good cells with in-order counts. Only the second of them produces a pulse.
- R5: When in sync, a good cell whose count is the expected one (previous + 1, modulo 8) raises `new_cell` for exactly one cycle, in the cycle after the cell is accepted.
- R6: When in sync, a good cell whose count is the expected count + 1 (one lost cell) produces two pulses in consecutive cycles and raises no error.
- R7: When in sync, a good cell whose count equals the previous count (one duplicate) produces no pulse and raises no error. The next expected count is unchanged.
- R8: When in sync and `cfg_snp_en` is high, a cell with bad protection is taken as the expected cell. It produces one pulse and raises no error.
- R9: A second anomaly (lost, duplicate, bad protection, or any other count) before an in-order good cell, or any count jump other than +1 or +2 or 0 while in sync, sets `oos_err` and produces no pulse. The tracker then hunts again.
- R10: `oos_err` and `lor_err` stay set until a one-cycle pulse on `clr_oos` or `clr_lor` clears them. A set condition in the same cycle as the clear wins.
- R11: With `cfg_timeout` = T (not 0), `lor_err` sets on the T-th `tick_8k` after the last accepted timing cell. T = 0 disables the timer. A timing cell accepted in the same cycle as a tick restarts the count, and that tick raises no error.
- R12: `cell_ready` is low only in the single cycle after a lost-cell acceptance. A cell held valid through that cycle is taken exactly once, on the next edge. After reset `cell_ready` is high and `new_cell`, `oos_err` and `lor_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | Cell present on the stream |
| cell_ready | output | 1 | Tracker can take a cell this cycle |
| cell_vpi | input | VPI_W | Cell VPI |
| cell_vci | input | VCI_W | Cell VCI |
| cell_oam | input | 1 | Cell is a maintenance cell |
| cell_hdr | input | 8 | AAL1 header byte of the cell |
| cfg_vpi | input | VPI_W | VPI of the timing connection |
| cfg_vci | input | VCI_W | VCI of the timing connection |
| cfg_snp_en | input | 1 | Enable sequence protection checking |
| cfg_timeout | input | TMO_W | Loss window in ticks, 0 disables |
| tick_8k | input | 1 | One-cycle strobe at the 8 kHz reference rate |
| clr_oos | input | 1 | Write-one-to-clear for `oos_err` |
| clr_lor | input | 1 | Write-one-to-clear for `lor_err` |
| new_cell | output | 1 | One pulse per accepted timing cell |
| oos_err | output | 1 | Sticky out-of-sync flag |
| lor_err | output | 1 | Sticky loss-of-reference flag |

## Verification
The timer has two events that can land in the same cycle: the restart caused by an accepted timing cell and the expiry caused by a tick. The bench drives a tick together with a timing cell one tick short of expiry. It then checks that `lor_err` stays low and that exactly the full window of further ticks is needed to raise it. The same kind of collision exists between a flag being set and its clear pulse. The bench sends the anomaly that sets `oos_err` in the same cycle as `clr_oos` and expects the flag to read high afterwards. The window is swept over several small values, and every sequence count is driven with both CSI values.

// File: rtl/tref_pkg.sv
package tref_pkg;

  localparam int SN_W = 3;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_SYNC    = 2'd1,
    ST_ONE_ERR = 2'd2,
    ST_OOS     = 2'd3
  } trk_state_e;

  // remainder of d(x)*x^3 divided by x^3 + x + 1
  function automatic logic [2:0] crc3_calc(input logic [3:0] d);
    logic [2:0] r;
    r = '0;
    for (int i = 3; i >= 0; i--) begin
      logic fb;
      fb = d[i] ^ r[2];
      r  = {r[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
    end
    return r;
  endfunction

endpackage

// File: rtl/tref_cell_filter.sv
module tref_cell_filter #(
  parameter int VPI_W = 12,
  parameter int VCI_W = 16
) (
  input  logic [VPI_W-1:0]         cell_vpi,
  input  logic [VCI_W-1:0]         cell_vci,
  input  logic                     cell_oam,
  input  logic [7:0]               cell_hdr,
  input  logic [VPI_W-1:0]         cfg_vpi,
  input  logic [VCI_W-1:0]         cfg_vci,
  output logic                     is_timing,
  output logic [tref_pkg::SN_W-1:0] sn,
  output logic                     snp_ok
);
  import tref_pkg::*;

  logic crc_ok;
  logic par_ok;

  always_comb begin
    is_timing = (cell_vpi == cfg_vpi) && (cell_vci == cfg_vci) && !cell_oam;
    sn        = cell_hdr[6:4];
    crc_ok    = (cell_hdr[3:1] == crc3_calc(cell_hdr[7:4]));
    par_ok    = ~(^cell_hdr);
    snp_ok    = crc_ok && par_ok;
  end

endmodule

// File: rtl/tref_seq_fsm.sv
module tref_seq_fsm (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic [tref_pkg::SN_W-1:0] sn,
  input  logic                      snp_ok,
  input  logic                      snp_en,
  input  logic                      clr_oos,
  output logic                      ready,
  output logic                      new_cell,
  output logic                      oos_err
);
  import tref_pkg::*;

  trk_state_e      st_q, st_d;
  logic [SN_W-1:0] exp_q, exp_d;
  logic            prev_q, prev_d;
  logic            pend_q;
  logic            nc_q;
  logic            oos_q;
  logic            ev1, ev2, oos_set, good;
  logic [SN_W-1:0] diff;

  always_comb begin
    good    = !snp_en || snp_ok;
    diff    = sn - exp_q;
    st_d    = st_q;
    exp_d   = exp_q;
    prev_d  = prev_q;
    ev1     = 1'b0;
    ev2     = 1'b0;
    oos_set = 1'b0;
    if (fire) begin
      case (st_q)
        ST_HUNT: begin
          if (good) begin
            if (prev_q && diff == '0) begin
              st_d = ST_SYNC;
              ev1  = 1'b1;
            end
            prev_d = 1'b1;
            exp_d  = sn + 1'b1;
          end
        end
        ST_SYNC: begin
          if (!good) begin
            st_d  = ST_ONE_ERR;
            ev1   = 1'b1;
            exp_d = exp_q + 1'b1;
          end else if (diff == '0) begin
            ev1   = 1'b1;
            exp_d = exp_q + 1'b1;
          end else if (diff == SN_W'(1)) begin
            st_d  = ST_ONE_ERR;
            ev1   = 1'b1;
            ev2   = 1'b1;
            exp_d = sn + 1'b1;
          end else if (diff == '1) begin
            st_d = ST_ONE_ERR;
          end else begin
            st_d    = ST_OOS;
            oos_set = 1'b1;
          end
        end
        ST_ONE_ERR: begin
          if (good && diff == '0) begin
            st_d  = ST_SYNC;
            ev1   = 1'b1;
            exp_d = exp_q + 1'b1;
          end else begin
            st_d    = ST_OOS;
            oos_set = 1'b1;
          end
        end
        default: begin
          if (good) begin
            st_d   = ST_HUNT;
            prev_d = 1'b1;
            exp_d  = sn + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      exp_q  <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      nc_q   <= 1'b0;
      oos_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      exp_q  <= exp_d;
      prev_q <= prev_d;
      pend_q <= ev2;
      nc_q   <= ev1 | pend_q;
      if (oos_set)      oos_q <= 1'b1;
      else if (clr_oos) oos_q <= 1'b0;
    end
  end

  assign ready    = !pend_q;
  assign new_cell = nc_q;
  assign oos_err  = oos_q;

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready); // R12
  AST_LOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> new_cell); // R6
  AST_LOST_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> new_cell); // R6
  AST_OOS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    oos_err && !clr_oos |=> oos_err); // R10
  AST_OOS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && st_q == ST_OOS |=> !new_cell); // R9
  AST_NO_FIRE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !fire); // R12

endmodule

// File: rtl/tref_loss_timer.sv
module tref_loss_timer #(
  parameter int TMO_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [TMO_W-1:0] limit,
  input  logic             clr,
  output logic             lor_err
);
  localparam logic [TMO_W:0] ONE = (TMO_W+1)'(1);

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   cnt_nx;
  logic             expire;
  logic             lor_q;

  always_comb begin
    cnt_nx = {1'b0, cnt_q} + ONE;
    expire = tick && !reload && (limit != '0) && (cnt_nx >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lor_q <= 1'b0;
    end else begin
      if (reload)                    cnt_q <= '0;
      else if (tick && cnt_q != '1)  cnt_q <= cnt_nx[TMO_W-1:0];
      if (expire)   lor_q <= 1'b1;
      else if (clr) lor_q <= 1'b0;
    end
  end

  assign lor_err = lor_q;

  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reload && !lor_err && !expire |=> !lor_err); // R11
  AST_TIMER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    limit == '0 && !lor_err |=> !lor_err); // R11
  AST_LOR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lor_err && !clr |=> lor_err); // R10

endmodule

// File: rtl/tref_seq_tracker.sv
module tref_seq_tracker #(
  parameter int VPI_W = 12,
  parameter int VCI_W = 16,
  parameter int TMO_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_valid,
  output logic             cell_ready,
  input  logic [VPI_W-1:0] cell_vpi,
  input  logic [VCI_W-1:0] cell_vci,
  input  logic             cell_oam,
  input  logic [7:0]       cell_hdr,
  input  logic [VPI_W-1:0] cfg_vpi,
  input  logic [VCI_W-1:0] cfg_vci,
  input  logic             cfg_snp_en,
  input  logic [TMO_W-1:0] cfg_timeout,
  input  logic             tick_8k,
  input  logic             clr_oos,
  input  logic             clr_lor,
  output logic             new_cell,
  output logic             oos_err,
  output logic             lor_err
);
  import tref_pkg::*;

  logic            is_timing;
  logic [SN_W-1:0] sn;
  logic            snp_ok;
  logic            rdy;
  logic            fire;

  tref_cell_filter #(.VPI_W(VPI_W), .VCI_W(VCI_W)) filt_i (
    .cell_vpi (cell_vpi),
    .cell_vci (cell_vci),
    .cell_oam (cell_oam),
    .cell_hdr (cell_hdr),
    .cfg_vpi  (cfg_vpi),
    .cfg_vci  (cfg_vci),
    .is_timing(is_timing),
    .sn       (sn),
    .snp_ok   (snp_ok)
  );

  assign fire       = cell_valid && rdy && is_timing;
  assign cell_ready = rdy;

  tref_seq_fsm fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .sn      (sn),
    .snp_ok  (snp_ok),
    .snp_en  (cfg_snp_en),
    .clr_oos (clr_oos),
    .ready   (rdy),
    .new_cell(new_cell),
    .oos_err (oos_err)
  );

  tref_loss_timer #(.TMO_W(TMO_W)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_8k),
    .reload (fire),
    .limit  (cfg_timeout),
    .clr    (clr_lor),
    .lor_err(lor_err)
  );

  AST_MISMATCH_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && cell_ready && (cell_vpi != cfg_vpi) && !new_cell && cell_ready |=> !new_cell); // R1
  AST_OAM_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && cell_oam && !new_cell && cell_ready |=> !new_cell); // R2

endmodule

// File: tb/tref_seq_tracker_tb_top.sv
module tref_seq_tracker_tb_top;

  localparam logic [11:0] V = 12'h05A;
  localparam logic [15:0] C = 16'h0123;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cell_valid = 1'b0;
  logic        cell_ready;
  logic [11:0] cell_vpi = '0;
  logic [15:0] cell_vci = '0;
  logic        cell_oam = 1'b0;
  logic [7:0]  cell_hdr = '0;
  logic [11:0] cfg_vpi = V;
  logic [15:0] cfg_vci = C;
  logic        cfg_snp_en = 1'b1;
  logic [9:0]  cfg_timeout = '0;
  logic        tick_8k = 1'b0;
  logic        clr_oos = 1'b0;
  logic        clr_lor = 1'b0;
  logic        new_cell, oos_err, lor_err;

  int n_vec = 0;
  int n_bad = 0;
  int tot_ev = 0;
  int nx = 0;
  logic nc_first, rdy_after;

  always #2.5 clk = ~clk;

  tref_seq_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_ready(cell_ready),
    .cell_vpi(cell_vpi), .cell_vci(cell_vci), .cell_oam(cell_oam), .cell_hdr(cell_hdr),
    .cfg_vpi(cfg_vpi), .cfg_vci(cfg_vci), .cfg_snp_en(cfg_snp_en), .cfg_timeout(cfg_timeout),
    .tick_8k(tick_8k), .clr_oos(clr_oos), .clr_lor(clr_lor),
    .new_cell(new_cell), .oos_err(oos_err), .lor_err(lor_err)
  );

  always @(negedge clk) if (rst_n && new_cell) tot_ev++;

  function automatic logic [7:0] mk2(input int sn, input int csi);
    int top, rem, ones, b8;
    top = (csi % 2) * 8 + (sn % 8);
    rem = top << 3;
    for (int b = 6; b >= 3; b--) if (((rem >> b) & 1) == 1) rem = rem ^ (11 << (b - 3));
    rem = rem & 7;
    b8 = (top << 4) | (rem << 1);
    ones = 0;
    for (int b = 1; b < 8; b++) ones += (b8 >> b) & 1;
    b8 = b8 | (ones % 2);
    return b8[7:0];
  endfunction

  function automatic logic [7:0] mk(input int sn);
    return mk2(sn, sn % 2);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] h, input logic oam, input logic [11:0] vp,
                      input logic [15:0] vc, input logic with_tick, input logic with_clr);
    cell_valid = 1'b1; cell_hdr = h; cell_oam = oam; cell_vpi = vp; cell_vci = vc;
    tick_8k = with_tick; clr_oos = with_clr;
    while (!cell_ready) @(negedge clk);
    @(negedge clk);
    cell_valid = 1'b0; tick_8k = 1'b0; clr_oos = 1'b0; cell_oam = 1'b0;
    nc_first = new_cell; rdy_after = cell_ready;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic go(input logic [7:0] h, output int evs);
    int base;
    base = tot_ev;
    send(h, 1'b0, V, C, 1'b0, 1'b0);
    settle();
    evs = tot_ev - base;
  endtask

  task automatic tick();
    tick_8k = 1'b1; @(negedge clk); tick_8k = 1'b0;
  endtask

  task automatic pulse_oos();
    clr_oos = 1'b1; @(negedge clk); clr_oos = 1'b0;
  endtask

  task automatic pulse_lor();
    clr_lor = 1'b1; @(negedge clk); clr_lor = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int e, base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset ready", cell_ready, 1);
    chk("R12 reset new_cell", new_cell, 0);
    chk("R12 reset oos_err", oos_err, 0);
    chk("R12 reset lor_err", lor_err, 0);

    // R4 hunt: first cell silent, second in order pulses
    go(mk(0), e); chk("R4 first hunt cell", e, 0);
    go(mk(1), e); chk("R4 second hunt cell", e, 1);
    nx = 2;
    for (int k = 0; k < 16; k++) begin
      base = tot_ev;
      send(mk(nx), 1'b0, V, C, 1'b0, 1'b0);
      chk("R5 pulse in cycle after accept", nc_first, 1);
      settle();
      chk("R5 one pulse per in-order cell", tot_ev - base, 1);
      nx++;
    end

    // R1 mismatched address ignored
    base = tot_ev;
    send(mk(nx), 1'b0, V ^ 12'h001, C, 1'b0, 1'b0); settle();
    chk("R1 vpi mismatch", tot_ev - base, 0);
    base = tot_ev;
    send(mk(nx), 1'b0, V, C ^ 16'h8000, 1'b0, 1'b0); settle();
    chk("R1 vci mismatch", tot_ev - base, 0);
    go(mk(nx), e); chk("R1 sequence unchanged", e, 1); nx++;

    // R2 OAM ignored
    base = tot_ev;
    send(mk(nx), 1'b1, V, C, 1'b0, 1'b0); settle();
    chk("R2 oam cell", tot_ev - base, 0);
    go(mk(nx), e); chk("R2 sequence unchanged", e, 1); nx++;

    // R6 single lost cell
    base = tot_ev;
    send(mk(nx + 1), 1'b0, V, C, 1'b0, 1'b0);
    chk("R6 ready low after lost", rdy_after, 0);
    settle();
    chk("R6 two pulses", tot_ev - base, 2);
    chk("R6 no error", oos_err, 0);
    nx += 2;
    go(mk(nx), e); chk("R6 resync", e, 1); nx++;

    // R7 duplicate
    go(mk(nx - 1), e); chk("R7 duplicate silent", e, 0);
    go(mk(nx), e); chk("R7 continues", e, 1); nx++;
    chk("R7 no error", oos_err, 0);

    // R8 bad protection in sync
    go(mk(nx) ^ 8'h02, e); chk("R8 bad crc pulses", e, 1); nx++;
    go(mk(nx), e); chk("R8 continues", e, 1); nx++;
    chk("R8 no error", oos_err, 0);

    // R3 parity only, then checking disabled
    go(mk(nx) ^ 8'h01, e); chk("R3 bad parity as anomaly", e, 1); nx++;
    go(mk(nx), e); chk("R3 recover", e, 1); nx++;
    cfg_snp_en = 1'b0;
    go(mk(nx) ^ 8'h02, e); chk("R3 disabled crc", e, 1); nx++;
    go(mk(nx) ^ 8'h01, e); chk("R3 disabled parity", e, 1); nx++;
    go(mk(nx) ^ 8'h0E, e); chk("R3 disabled all crc", e, 1); nx++;
    chk("R3 disabled no error", oos_err, 0);
    cfg_snp_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      go(mk2(nx, (nx + 1) % 2), e); chk("R3 csi sweep", e, 1); nx++;
    end

    // R12 back-to-back across stall
    base = tot_ev;
    send(mk(nx + 1), 1'b0, V, C, 1'b0, 1'b0);
    chk("R12 stall cycle", rdy_after, 0);
    send(mk(nx + 2), 1'b0, V, C, 1'b0, 1'b0);
    settle();
    chk("R12 held cell taken", tot_ev - base, 3);
    nx += 3;
    go(mk(nx), e); chk("R12 taken once", e, 1); nx++;
    chk("R12 no error", oos_err, 0);

    // R9 two duplicates
    go(mk(nx - 1), e); chk("R9 first dup", e, 0);
    go(mk(nx - 1), e); chk("R9 second dup silent", e, 0);
    chk("R9 oos set", oos_err, 1);
    pulse_oos();
    chk("R10 oos cleared", oos_err, 0);
    go(mk(5), e); chk("R9 rehunt first", e, 0);
    go(mk(6), e); chk("R9 rehunt second", e, 1);
    nx = 7;
    go(mk(nx + 3), e); chk("R9 big jump silent", e, 0);
    chk("R9 big jump oos", oos_err, 1);
    pulse_oos();
    go(mk(3), e); chk("R4 hunt after jump", e, 0);
    go(mk(4), e); chk("R4 sync after jump", e, 1);
    nx = 5;

    // R10 set beats clear
    go(mk(nx - 1), e); chk("R10 dup", e, 0);
    send(mk(nx - 1), 1'b0, V, C, 1'b0, 1'b1); settle();
    chk("R10 set wins over clear", oos_err, 1);
    pulse_oos();
    chk("R10 cleared", oos_err, 0);
    go(mk(0), e); go(mk(1), e); chk("R4 resync", e, 1);
    nx = 2;

    // R11 timeout sweep
    for (int t = 1; t <= 6; t++) begin
      cfg_timeout = 10'(t);
      go(mk(nx), e); nx++;
      pulse_lor();
      for (int j = 0; j < t - 1; j++) tick();
      chk("R11 before window", lor_err, 0);
      tick();
      chk("R11 at window", lor_err, 1);
      tick();
      chk("R10 lor sticky", lor_err, 1);
    end
    cfg_timeout = '0;
    pulse_lor();
    chk("R10 lor cleared", lor_err, 0);
    repeat (30) tick();
    chk("R11 disabled", lor_err, 0);

    cfg_timeout = 10'd2;
    go(mk(nx), e); nx++;
    tick();
    send(mk(nx), 1'b0, V, C, 1'b1, 1'b0); nx++; settle();
    chk("R11 reload beats tick", lor_err, 0);
    tick();
    chk("R11 window restarted", lor_err, 0);
    tick();
    chk("R11 window after reload", lor_err, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule